// File: doc/BRIEF.md
# Shared Power-Down / Interrupt Pin Controller

This block sits in the management plane of a network transceiver. It lets one active-low pad serve two purposes. After reset the pad is an input: pulling it low asks the device to power down, exactly as if software had set the power-down bit of the basic control register. Once software sets the output-enable bit of the interrupt control register, the pad level no longer requests power-down. The block can then pull the pad low to signal an interrupt. The pad is open-drain: the block only ever drives it low or releases it.

Internal sources send single-cycle event pulses, for link-status change and for energy-detect change. Each source has an enable bit in the low byte of the interrupt status register. An enabled event latches a pending flag in the high byte. The pad is pulled low straight from the pending flags through gates, with no further register, as long as interrupts are enabled. Software finds out which sources fired by reading the status register. That read clears every pending flag at once, which releases the pad. An event that arrives in the same cycle as the clearing read is kept.

Register access uses a simple synchronous port. Writes take effect at the clock edge. Read data is a combinational decode of the address.

Top module: `pdint_ctrl`

## Requirements
- R1: After reset, the basic control register (address 0x00), the interrupt control register (0x11) and the status register (0x12) all read 0. The pad is released. With the pad high, no power-down is requested.
- R2: While output-enable is 0, a low pad raises `pwrdn_req_o` after exactly two rising clock edges, and a high pad removes the request after two edges. This includes a pad held low through reset. The pad is never pulled low while output-enable is 0.
- R3: Bit 11 of register 0x00 is writable and reads back. Its other bits read 0. While bit 11 is 1, `pwrdn_req_o` is 1 whatever the pad level.
- R4: While bit 0 (output-enable) of 0x11 is 1, the pad level has no effect on `pwrdn_req_o`. Clearing the bit restores the effect at once.
- R5: Bits 7:0 of 0x12 are writable per-source enables: bit 5 is link change and bit 6 is energy-detect change. Writes to bits 15:8 are ignored.
- R6: An event pulse sets its pending flag only if the source's enable bit is 1 at that edge. Link change is flagged at bit 13 and energy-detect change at bit 14 of 0x12.
- R7: The pad is pulled low whenever all three of these hold: output-enable (bit 0 of 0x11) is 1, interrupt-enable (bit 1 of 0x11) is 1, and some pending flag has its enable bit set. This takes effect in the same cycle the flag or the control bit changes, with no added clock delay.
- R8: A read of 0x12 returns the pending flags and then clears all of them at the clock edge, releasing the pad.
- R9: An enabled event arriving in the same cycle as a clearing read of 0x12 remains pending afterwards.
- R10: Both sources can be pending at the same time, and both flags read back together.
- R11: Addresses other than 0x00, 0x11 and 0x12 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status on 0x12) |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the current address |
| evt_i | input | 2 | Event pulses: bit 0 link change, bit 1 energy-detect change |
| pad_i | input | 1 | Level seen on the shared pad |
| pad_pull_low_o | output | 1 | 1 pulls the pad low; 0 releases it |
| pwrdn_req_o | output | 1 | Combined power-down request |

## Verification
If a pending flag is set or cleared wrongly, the pad pull changes in the very cycle after the faulty edge. The wrong value also shows on the next read of 0x12. A lost clash event shows as a released pad right after the read that should have kept it low. A synchronizer that is too short or too long moves the `pwrdn_req_o` transition off the second edge after a pad change. A mis-gated output-enable shows at once on `pwrdn_req_o` while the pad is held low.

// File: rtl/pdint_pkg.sv
package pdint_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 5;
  localparam int NUM_SRC = 2;

  localparam logic [ADDR_W-1:0] A_BASIC = 5'h00;
  localparam logic [ADDR_W-1:0] A_ICTRL = 5'h11;
  localparam logic [ADDR_W-1:0] A_ISTAT = 5'h12;

  localparam int PD_BIT  = 11;
  localparam int OE_BIT  = 0;
  localparam int IEN_BIT = 1;
  localparam int HALF_W  = REG_W / 2;

  // enable bit of each source in the low byte: 0 = link, 1 = energy detect
  localparam int SRC_EN_POS [NUM_SRC] = '{5, 6};

  function automatic int pend_pos(int src);
    return SRC_EN_POS[src] + HALF_W;
  endfunction

  function automatic logic irq_level(logic [HALF_W-1:0] flags,
                                     logic [HALF_W-1:0] mask,
                                     logic inten);
    return inten & (|(flags & mask));
  endfunction
endpackage

// File: rtl/pdint_sync.sv
module pdint_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdint_evt_latch.sv
module pdint_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic en_i,
  input  logic clr_i,
  output logic pend_o
);
  logic arm;
  assign arm = evt_i & en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= (pend_o & ~clr_i) | arm;
  end

  assert_set_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_o && !arm) |=> !pend_o);

  assert_keep_on_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> pend_o);
endmodule

// File: rtl/pdint_ctrl.sv
module pdint_ctrl
  import pdint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic              pad_i,
  output logic              pad_pull_low_o,
  output logic              pwrdn_req_o
);
  logic              bmcr_pd;
  logic              ctrl_oe;
  logic              ctrl_ien;
  logic [HALF_W-1:0] src_mask;
  logic [NUM_SRC-1:0] pend_src;
  logic [HALF_W-1:0] flag_byte;
  logic              pad_sync;
  logic              pin_pd_req;
  logic              irq_active;

  // named decode events, used by the assertions as well
  logic wr_basic, wr_ictrl, wr_istat, rd_istat;
  assign wr_basic = reg_wr_i && (reg_addr_i == A_BASIC);
  assign wr_ictrl = reg_wr_i && (reg_addr_i == A_ICTRL);
  assign wr_istat = reg_wr_i && (reg_addr_i == A_ISTAT);
  assign rd_istat = reg_rd_i && (reg_addr_i == A_ISTAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bmcr_pd  <= 1'b0;
      ctrl_oe  <= 1'b0;
      ctrl_ien <= 1'b0;
      src_mask <= '0;
    end else begin
      if (wr_basic) bmcr_pd <= reg_wdata_i[PD_BIT];
      if (wr_ictrl) begin
        ctrl_oe  <= reg_wdata_i[OE_BIT];
        ctrl_ien <= reg_wdata_i[IEN_BIT];
      end
      if (wr_istat) src_mask <= reg_wdata_i[HALF_W-1:0];
    end
  end

  // per-source pending flags
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    pdint_evt_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i[s]),
      .en_i   (src_mask[SRC_EN_POS[s]]),
      .clr_i  (rd_istat),
      .pend_o (pend_src[s])
    );
  end

  always_comb begin
    flag_byte = '0;
    for (int s = 0; s < NUM_SRC; s++)
      flag_byte[pend_pos(s) - HALF_W] = pend_src[s];
  end

  // pad input path
  pdint_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pad_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  assign pin_pd_req  = ~pad_sync & ~ctrl_oe;
  assign pwrdn_req_o = bmcr_pd | pin_pd_req;

  // interrupt output: gates only, no clock between flags and pad
  assign irq_active     = irq_level(flag_byte, src_mask, ctrl_ien);
  assign pad_pull_low_o = ctrl_oe & irq_active;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_BASIC: reg_rdata_o[PD_BIT] = bmcr_pd;
      A_ICTRL: begin
        reg_rdata_o[OE_BIT]  = ctrl_oe;
        reg_rdata_o[IEN_BIT] = ctrl_ien;
      end
      A_ISTAT: reg_rdata_o = {flag_byte, src_mask};
      default: reg_rdata_o = '0;
    endcase
  end

  assert_basic_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_basic |=> (reg_addr_i != A_BASIC) || (reg_rdata_o[PD_BIT] == $past(reg_wdata_i[PD_BIT])));

  assert_oe_masks_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_oe |-> (pwrdn_req_o == bmcr_pd));

  assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_istat |=> src_mask == $past(reg_wdata_i[HALF_W-1:0]));

  assert_read_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_istat && evt_i == '0) |=> !pad_pull_low_o);

  assert_no_drive_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_oe && !wr_ictrl) |=> !pad_pull_low_o);
endmodule

// File: tb/pdint_ctrl_tb_top.sv
`timescale 1ns/1ps
module pdint_ctrl_tb_top;
  localparam time TCK = 20ns;

  typedef struct packed {
    logic [1:0]  op;      // 0 idle, 1 write, 2 read
    logic [4:0]  addr;
    logic [15:0] wd;
    logic [1:0]  evt;     // bit0 link, bit1 energy
    logic        pad;
    logic [15:0] exp_rd;
    logic        exp_pull;
    logic        exp_pwr;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t v(int op, int addr, int wd, int evt, int pad,
                             int rd, int pull, int pwr, int req);
    vec_t t;
    t.op = 2'(op); t.addr = 5'(addr); t.wd = 16'(wd); t.evt = 2'(evt);
    t.pad = 1'(pad); t.exp_rd = 16'(rd); t.exp_pull = 1'(pull);
    t.exp_pwr = 1'(pwr); t.req = 4'(req);
    return t;
  endfunction

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    v(2,'h00,0,0,1,'h0000,0,0,1),      // R1
    v(2,'h11,0,0,1,'h0000,0,0,1),      // R1
    v(2,'h12,0,0,1,'h0000,0,0,1),      // R1
    v(1,'h12,'hFFFF,0,1,0,0,0,5),
    v(2,'h12,0,0,1,'h00FF,0,0,5),      // R5 high byte ignored
    v(1,'h12,'h0000,0,1,0,0,0,5),
    v(0,0,0,1,1,0,0,0,6),              // R6 link while disabled
    v(2,'h12,0,0,1,'h0000,0,0,6),
    v(1,'h12,'h0060,0,1,0,0,0,5),
    v(1,'h11,'h0003,0,1,0,0,0,7),
    v(0,0,0,1,1,0,1,0,7),              // R7 link pending pulls pad
    v(2,'h12,0,0,1,'h2060,0,0,8),      // R8 read then release
    v(2,'h12,0,0,1,'h0060,0,0,8),      // R8 cleared
    v(0,0,0,3,1,0,1,0,10),             // R10 both
    v(2,'h12,0,0,1,'h6060,0,0,10),
    v(2,'h12,0,2,1,'h0060,1,0,9),      // R9 clash keeps energy
    v(2,'h12,0,0,1,'h4060,0,0,9),
    v(1,'h11,'h0001,0,1,0,0,0,7),
    v(0,0,0,1,1,0,0,0,7),              // R7 inten off, no pull
    v(1,'h11,'h0003,0,1,0,1,0,7),      // R7 inten on, pull at once
    v(2,'h12,0,0,1,'h2060,0,0,8),
    v(1,'h11,'h0000,0,1,0,0,0,2),
    v(0,0,0,1,1,0,0,0,2),              // R2 no drive in input mode
    v(2,'h11,0,0,1,'h0000,0,0,2),
    v(2,'h12,0,0,1,'h2060,0,0,8),
    v(1,'h00,'h0800,0,1,0,0,1,3),      // R3
    v(2,'h00,0,0,1,'h0800,0,1,3),
    v(1,'h00,'h0000,0,1,0,0,0,3),
    v(1,'h1F,'hFFFF,0,1,0,0,0,11),
    v(2,'h1F,0,0,1,'h0000,0,0,11),     // R11
    v(2,'h00,0,0,1,'h0000,0,0,11),
    v(1,'h00,'hFFFF,0,1,0,0,1,3),
    v(2,'h00,0,0,1,'h0800,0,1,3),      // R3 other bits read 0
    v(1,'h00,'h0000,0,1,0,0,0,3)
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  evt = '0;
  logic        pad = 1'b1;
  logic        pull, pwr;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCK/2) clk = ~clk;

  pdint_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .evt_i(evt), .pad_i(pad), .pad_pull_low_o(pull), .pwrdn_req_o(pwr)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_bus();
    reg_wr = 1'b0; reg_rd = 1'b0; evt = '0;
  endtask

  task automatic wr_reg(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    idle_bus();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(TCK * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state at the ports (R1)
    #1;
    chk("R1 pull", 16'(pull), 16'h0);
    chk("R1 pwr", 16'(pwr), 16'h0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[k].req, k);
      @(negedge clk);
      reg_wr    = (VEC[k].op == 2'd1);
      reg_rd    = (VEC[k].op == 2'd2);
      reg_addr  = VEC[k].addr;
      reg_wdata = VEC[k].wd;
      evt       = VEC[k].evt;
      pad       = VEC[k].pad;
      #1;
      if (VEC[k].op == 2'd2) chk({tag, " rdata"}, reg_rdata, VEC[k].exp_rd);
      @(posedge clk);
      @(negedge clk);
      chk({tag, " pull"}, 16'(pull), 16'(VEC[k].exp_pull));
      chk({tag, " pwr"}, 16'(pwr), 16'(VEC[k].exp_pwr));
      idle_bus();
    end

    // R2: pad low in input mode, two-edge latency
    @(negedge clk);
    pad = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 one edge", 16'(pwr), 16'h0);
    @(posedge clk); @(negedge clk);
    chk("R2 two edges", 16'(pwr), 16'h1);
    chk("R2 no pull", 16'(pull), 16'h0);

    // R4: output-enable masks the pad
    wr_reg(5'h11, 16'h0001);
    chk("R4 oe masks pad", 16'(pwr), 16'h0);
    wr_reg(5'h11, 16'h0000);
    chk("R4 oe cleared", 16'(pwr), 16'h1);

    // R2: pad released
    @(negedge clk);
    pad = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 release one edge", 16'(pwr), 16'h1);
    @(posedge clk); @(negedge clk);
    chk("R2 release two edges", 16'(pwr), 16'h0);

    // R2: pad held low through reset
    rst_n = 1'b0;
    pad = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R2 after reset", 16'(pwr), 16'h0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 start in power-down", 16'(pwr), 16'h1);
    pad = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    summary();
  end
endmodule